// File: doc/BRIEF.md
# Column-Serial AES-128 Encryption Core

This core encrypts one 128-bit block under a 128-bit key with AES-128. To keep the circuit small, it computes the round on a 32-bit path. Each clock cycle produces one new state column, so a round takes four cycles.

The byte substitution and the column-mixing constant products come from four word-wide lookup functions, one for each row position. Each one returns a 32-bit word for an input byte, and the four words are combined with XOR alone. The row rotation costs no storage, because the core reads the state bytes at shifted column indices. Each round derives its round key from the previous one while the round runs. This means every block may carry a fresh key and needs no preload phase.

The user raises `start_i` while `ready_o` is high. The key and plaintext are captured on that edge, and `done_o` pulses forty cycles later. At that point `ct_o` holds the ciphertext, and a new block may be started in the same cycle.

Top module: `aes128_colserial`

## Requirements
- R1: While reset is asserted and right after it is released, `ready_o` is 1, `done_o` is 0 and `ct_o` is all zeros.
- R2: A start is accepted on a rising edge where `start_i` and `ready_o` are both 1. `key_i` and `pt_i` are captured on that edge, and `ready_o` is 0 from the next cycle until the block completes.
- R3: A start request made while `ready_o` is 0 has no effect. The running block's ciphertext is unchanged and no extra `done_o` pulse appears.
- R4: `ct_o` equals the AES-128 encryption of `pt_i` under `key_i`. In all three 128-bit buses, byte 0 of the block sits in bits 127:120 and the bytes follow in order toward bit 0.
- R5: `done_o` is high for exactly one cycle, after the 40th rising edge that follows the accepting edge. `ready_o` rises in that same cycle.
- R6: `ct_o` changes only on the edge that raises `done_o`, and it holds its value at all other times.
- R7: A start presented in the cycle where `done_o` is high is accepted at once, so blocks can run back to back with no idle cycle.
- R8: Consecutive blocks may use different keys, and each block is encrypted correctly under its own key with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a block |
| key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| pt_i | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| ready_o | output | 1 | Core idle and able to accept a start |
| ct_o | output | 128 | Ciphertext of the last finished block |
| done_o | output | 1 | One-cycle pulse when `ct_o` is updated |

## Verification
Completion of one block and acceptance of the next can fall on the same edge. On that edge the core must publish the final state, pulse `done_o`, and reload its state and key registers with new operands.

The bench provokes this case by keeping a queue of blocks with differing keys. The driver raises `start_i` in the very cycle that `done_o` is visible.

Each pulse is judged against a queue of expected ciphertexts that an independent model computes. The bench checks three things for each pulse:
- the ciphertext matches the expected value;
- the pulse arrives exactly 40 cycles after its own accepting edge;
- the previous result was not disturbed by the new load.

// File: rtl/aes128_colserial.sv
module aes128_colserial (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [127:0] key_i,
  input  logic [127:0] pt_i,
  output logic         ready_o,
  output logic [127:0] ct_o,
  output logic         done_o
);
  localparam int NR = 10;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xt(x);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, x252, inv;
    x2   = gmul(a, a);
    x3   = gmul(x2, a);
    x6   = gmul(x3, x3);
    x12  = gmul(x6, x6);
    x15  = gmul(x12, x3);
    x30  = gmul(x15, x15);
    x60  = gmul(x30, x30);
    x120 = gmul(x60, x60);
    x240 = gmul(x120, x120);
    x252 = gmul(x240, x12);
    inv  = gmul(x252, x2);
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // merged substitution + column-mix entry for a given row position
  function automatic logic [31:0] tword(input logic [7:0] a, input int row);
    logic [7:0]  s;
    logic [31:0] w;
    s = sbox(a);
    w = {xt(s), s, s, xt(s) ^ s};
    return (w >> (8 * row)) | (w << (32 - 8 * row));
  endfunction

  function automatic logic [7:0] getb(input logic [127:0] st, input int r, input logic [1:0] c);
    return st[8 * (15 - (4 * int'(c) + r)) +: 8];
  endfunction

  function automatic logic [31:0] getw(input logic [127:0] st, input logic [1:0] c);
    return st[32 * (3 - int'(c)) +: 32];
  endfunction

  logic [127:0] st_q, sh_q, key_q, ct_q;
  logic [7:0]   rcon_q;
  logic [3:0]   rnd_q;
  logic [1:0]   col_q;
  logic         busy_q, done_q;

  logic [31:0] t0, t1, t2, t3, mixw, subw, kprev, kleft, k3, gw, rkw, neww;
  logic        last, accept;

  assign ready_o = !busy_q;
  assign done_o  = done_q;
  assign ct_o    = ct_q;
  assign accept  = start_i && !busy_q;
  assign last    = (rnd_q == 4'(NR));

  // row rotation by index selection only
  assign t0 = tword(getb(st_q, 0, col_q), 0);
  assign t1 = tword(getb(st_q, 1, col_q + 2'd1), 1);
  assign t2 = tword(getb(st_q, 2, col_q + 2'd2), 2);
  assign t3 = tword(getb(st_q, 3, col_q + 2'd3), 3);

  assign mixw = t0 ^ t1 ^ t2 ^ t3;
  assign subw = {t0[23:16], t1[15:8], t2[7:0], t3[31:24]};

  assign kprev = getw(key_q, col_q);
  assign kleft = getw(key_q, col_q - 2'd1);
  assign k3    = getw(key_q, 2'd3);
  assign gw    = {sbox(k3[23:16]) ^ rcon_q, sbox(k3[15:8]), sbox(k3[7:0]), sbox(k3[31:24])};
  assign rkw   = kprev ^ ((col_q == 2'd0) ? gw : kleft);
  assign neww  = (last ? subw : mixw) ^ rkw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      sh_q   <= '0;
      key_q  <= '0;
      ct_q   <= '0;
      rcon_q <= 8'h01;
      rnd_q  <= 4'd0;
      col_q  <= 2'd0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q   <= pt_i ^ key_i;
        key_q  <= key_i;
        rcon_q <= 8'h01;
        rnd_q  <= 4'd1;
        col_q  <= 2'd0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        key_q[32 * (3 - int'(col_q)) +: 32] <= rkw;
        sh_q[32 * (3 - int'(col_q)) +: 32]  <= neww;
        col_q <= col_q + 2'd1;
        if (col_q == 2'd3) begin
          st_q   <= {sh_q[127:32], neww};
          rcon_q <= xt(rcon_q);
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            ct_q   <= {sh_q[127:32], neww};
          end else begin
            rnd_q <= rnd_q + 4'd1;
          end
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start_i && ready_o) |=> (!ready_o && !done_o));
  // R6
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(ct_o));
  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ready_o);
  // R5
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (rnd_q >= 4'd1 && rnd_q <= 4'(NR)));
  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !(last && col_q == 2'd3)) |=> busy_q);
endmodule

// File: tb/aes128_colserial_tb_top.sv
`timescale 1ns/1ps
module aes128_colserial_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0, pt_i = '0;
  logic         ready_o, done_o;
  logic [127:0] ct_o;

  aes128_colserial dut_i (.clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
                          .pt_i(pt_i), .ready_o(ready_o), .ct_o(ct_o), .done_o(done_o));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, n_sent = 0, n_done = 0, cyc = 0, accept_cyc = 0;
  logic [127:0] expq[$];
  logic [127:0] last_ct = '0;
  logic [7:0] sb [256];

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    for (int i = 0; i < 255; i++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [31:0] w [44];
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [31:0] tmp;
    logic [7:0]  rc, a0, a1, a2, a3;
    logic [127:0] out;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127 - 32 * i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i - 1];
      if (i % 4 == 0) begin
        tmp = {sb[tmp[23:16]] ^ rc, sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]};
        rc = xt(rc);
      end
      w[i] = w[i - 4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127 - 8 * i -: 8] ^ w[i / 4][31 - 8 * (i % 4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4 * c + r] = t[4 * ((c + r) % 4) + r];
      if (rd < 10)
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4 * rd + i / 4][31 - 8 * (i % 4) -: 8];
    end
    for (int i = 0; i < 16; i++) out[127 - 8 * i -: 8] = s[i];
    return out;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // driver: push expected item, start block
  task automatic send(input logic [127:0] k, input logic [127:0] p, input logic [127:0] exp);
    while (!ready_o) @(negedge clk);
    key_i = k; pt_i = p; start_i = 1'b1;
    @(posedge clk);
    #1;
    accept_cyc = cyc;
    expq.push_back(exp);
    n_sent++;
    @(negedge clk);
    start_i = 1'b0;
    key_i = ~k; pt_i = ~p;
  endtask

  // R3: start while busy with junk operands
  task automatic poke_busy(input int n);
    for (int i = 0; i < n; i++) begin
      check(ready_o == 1'b0, "R2 ready low while busy", 128'(ready_o), 128'd0);
      start_i = 1'b1; key_i = {4{$urandom}}; pt_i = {4{$urandom}};
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        n_done++;
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected done", ct_o, '0);
        end else begin
          logic [127:0] e;
          e = expq.pop_front();
          check(ct_o === e, "R4/R8 ciphertext", ct_o, e);
          check(cyc - accept_cyc == 40, "R5 latency", 128'(cyc - accept_cyc), 128'd40);
          check(ready_o === 1'b1, "R5/R7 ready with done", 128'(ready_o), 128'd1);
        end
      end else begin
        check(ct_o === last_ct, "R6 ct held", ct_o, last_ct);
      end
      last_ct = ct_o;
    end
  end

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] k, p;
    build_sbox();
    repeat (3) @(negedge clk);
    check(ready_o === 1'b1 && done_o === 1'b0 && ct_o === '0, "R1 reset state",
          {ready_o, done_o, ct_o[125:0]}, {1'b1, 127'd0});
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o === 1'b1 && done_o === 1'b0 && ct_o === '0, "R1 after release",
          {ready_o, done_o, ct_o[125:0]}, {1'b1, 127'd0});
    check(ref_enc(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff)
          === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 model sanity",
          ref_enc(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff),
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    // R4 published vectors, back to back with different keys (R7, R8)
    send(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
         128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    send(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
         128'h3925841d02dc09fbdc118597196a0b32);
    // R3: ignored starts during a block
    k = {$urandom, $urandom, $urandom, $urandom};
    p = {$urandom, $urandom, $urandom, $urandom};
    send(k, p, ref_enc(k, p));
    poke_busy(6);
    // corner operands
    send('0, '0, ref_enc('0, '0));
    send('1, '1, ref_enc('1, '1));
    send('0, '1, ref_enc('0, '1));
    // R8: random keys, back to back
    for (int i = 0; i < 6; i++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      send(k, p, ref_enc(k, p));
    end
    while (expq.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    check(n_done == n_sent, "R3 done count", 128'(n_done), 128'(n_sent));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule